// File: doc/BRIEF.md
# Block-Pattern Memory Self-Test Engine

This block is a built-in self-test controller for a word-addressed synchronous memory whose width is a power of two. It does not walk a one and a zero through every bit. Instead it drives a short series of background words. The first half of the series is a set of alternating-block words whose block length halves at each step, ending in the all-zero word. The second half repeats the first half in complement. For a width of N this takes 2*(1 + log2 N) backgrounds rather than 2N. Together the backgrounds expose stuck-at bits and shorts between neighbouring bits.

For each background the engine writes every address in ascending order. Only then does it read every address back in the same order. It compares each returned word against the background it expects. The first mismatch is recorded: its background index, its address, and the XOR of the expected and returned data as a bit mask.

A configuration input sampled at start chooses between two behaviours: stop at the first error, or run every background to the end. A one-cycle done pulse marks the end of a run.

Top module: `pattern_bist`

## Requirements
- R1: Background k, for k below L = log2(DATA_W), has bit i set to 1 exactly when bit (L-1-k) of i is 0 (for DATA_W=8: 0x0F, 0x33, 0x55). Background L is all zeros. Backgrounds L+1 to 2L+1 are the complements of backgrounds 0 to L, in the same order. Index 0 is used first.
- R2: For each background, the engine writes addresses 0 to DEPTH-1 in consecutive cycles, then reads 0 to DEPTH-1 in consecutive cycles, then spends one idle cycle before the next background. No read is issued before the write pass is complete.
- R3: A returned word that differs from the expected background in any bit makes `passed` low at the end of the run.
- R4: `failPat`, `failAddr` and `failMask` hold the first mismatch in run order. `failMask` is the expected data XOR the read data. Later mismatches do not change these outputs. `start` clears them to zero.
- R5: With `haltOnErr` high at start, the run ends right after the first mismatch. With it low, the run always covers all backgrounds.
- R6: `done` is high for exactly one cycle. In a full run it rises NUM_PAT*(2*DEPTH+1) cycles after the start edge.
- R7: Read data is taken one cycle after the read request. In halting mode, a mismatch on the read of address a in background p therefore puts `done` high p*(2*DEPTH+1)+DEPTH+a+2 cycles after the start edge.
- R8: `start` is ignored while `busy` is high. The run's timing and results are unchanged.
- R9: After reset, and after a run with no mismatch, `passed` is 1 and the three failure outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| haltOnErr | input | 1 | 1: stop at first mismatch; sampled at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| passed | output | 1 | No mismatch seen since start |
| failPat | output | PAT_W | Background index of first mismatch |
| failAddr | output | ADDR_W | Address of first mismatch |
| failMask | output | DATA_W | Failing bit mask of first mismatch |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid the cycle after a read request |

## Verification
The bench counts cycles from the edge that samples `start`. It expects the memory request of step s in the cycle right after edge s. It expects `done` after edge NUM_PAT*(2*DEPTH+1) in a full run, and after edge p*(2*DEPTH+1)+DEPTH+a+2 when the engine halts on address a of background p. Every sample is taken at the falling edge, once all registers on the path have settled. The failure outputs are compared once `done` is seen. The bench also checks that `done` has dropped one cycle later.

// File: rtl/pattern_bist_pkg.sv
package pattern_bist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DRAIN,
    ST_FINISH
  } bist_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic doWrite;
    logic doRead;
    logic addrStep;
    logic patStep;
  } bist_strobe_t;

endpackage

// File: rtl/pattern_bist_ctrl.sv
module pattern_bist_ctrl
  import pattern_bist_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         haltOnErr,
  input  logic         addrLast,
  input  logic         patLast,
  input  logic         mismatch,
  output bist_strobe_t strobe,
  output logic         busy,
  output logic         done
);

  bist_state_e state, nextState;
  logic        haltQ;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clearAll = 1'b1;
          nextState       = ST_WRITE;
        end
      end
      ST_WRITE: begin
        strobe.doWrite  = 1'b1;
        strobe.addrStep = 1'b1;
        if (addrLast) nextState = ST_READ;
      end
      ST_READ: begin
        if (mismatch && haltQ) begin
          nextState = ST_FINISH;
        end else begin
          strobe.doRead   = 1'b1;
          strobe.addrStep = 1'b1;
          if (addrLast) nextState = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if ((mismatch && haltQ) || patLast) begin
          nextState = ST_FINISH;
        end else begin
          strobe.patStep = 1'b1;
          nextState      = ST_WRITE;
        end
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      haltQ <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.clearAll) haltQ <= haltOnErr;
    end
  end

  assign busy = (state == ST_WRITE) || (state == ST_READ) || (state == ST_DRAIN);
  assign done = (state == ST_FINISH);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (haltQ && mismatch && (state == ST_READ || state == ST_DRAIN)) |=> done);

  // R2
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doRead && !$past(strobe.doRead)) |-> $past(strobe.doWrite && addrLast));

endmodule

// File: rtl/pattern_bist_dp.sv
module pattern_bist_dp
  import pattern_bist_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int LOG_W   = 3,
  parameter int NUM_PAT = 8,
  parameter int PAT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bist_strobe_t      strobe,
  output logic              addrLast,
  output logic              patLast,
  output logic              mismatch,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              passed,
  output logic [PAT_W-1:0]  failPat,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failMask
);

  logic [ADDR_W-1:0] addr;
  logic [PAT_W-1:0]  patIdx;
  logic [DATA_W-1:0] curPat, expQ;
  logic [ADDR_W-1:0] cmpAddrQ;
  logic [PAT_W-1:0]  cmpPatQ;
  logic              cmpValid, errSeen;

  function automatic logic [DATA_W-1:0] backgroundOf(input logic [PAT_W-1:0] idx);
    logic [DATA_W-1:0] v;
    int ii, kk;
    logic inv;
    ii  = int'(idx);
    inv = (ii > LOG_W);
    kk  = inv ? ii - (LOG_W + 1) : ii;
    for (int i = 0; i < DATA_W; i++) begin
      v[i] = (kk < LOG_W) ? (((i >> (LOG_W - 1 - kk)) & 1) == 0) : 1'b0;
    end
    return inv ? ~v : v;
  endfunction

  assign curPat   = backgroundOf(patIdx);
  assign addrLast = (addr == '1);
  assign patLast  = (patIdx == PAT_W'(NUM_PAT - 1));
  assign mismatch = cmpValid && (memRdata != expQ);

  assign memEn    = strobe.doWrite || strobe.doRead;
  assign memWe    = strobe.doWrite;
  assign memAddr  = addr;
  assign memWdata = curPat;
  assign passed   = !errSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr     <= '0;
      patIdx   <= '0;
      expQ     <= '0;
      cmpAddrQ <= '0;
      cmpPatQ  <= '0;
      cmpValid <= 1'b0;
      errSeen  <= 1'b0;
      failPat  <= '0;
      failAddr <= '0;
      failMask <= '0;
    end else if (strobe.clearAll) begin
      addr     <= '0;
      patIdx   <= '0;
      cmpValid <= 1'b0;
      errSeen  <= 1'b0;
      failPat  <= '0;
      failAddr <= '0;
      failMask <= '0;
    end else begin
      if (strobe.addrStep) addr <= addr + 1'b1;
      if (strobe.patStep)  patIdx <= patIdx + 1'b1;
      cmpValid <= strobe.doRead;
      if (strobe.doRead) begin
        expQ     <= curPat;
        cmpAddrQ <= addr;
        cmpPatQ  <= patIdx;
      end
      if (mismatch && !errSeen) begin
        errSeen  <= 1'b1;
        failPat  <= cmpPatQ;
        failAddr <= cmpAddrQ;
        failMask <= expQ ^ memRdata;
      end
    end
  end

  // R4
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (errSeen && !strobe.clearAll) |=> ($stable(failPat) && $stable(failAddr) && $stable(failMask)));

  // R1
  zero_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doWrite && patIdx == PAT_W'(LOG_W)) |-> (memWdata == '0));

  // R1
  ones_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doWrite && patLast) |-> (memWdata == '1));

  // R2
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doWrite && $past(strobe.doWrite)) |-> (memAddr == $past(memAddr) + 1'b1));

endmodule

// File: rtl/pattern_bist.sv
module pattern_bist
  import pattern_bist_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int LOG_W   = $clog2(DATA_W),
  localparam int NUM_PAT = 2 * (1 + LOG_W),
  localparam int PAT_W   = $clog2(NUM_PAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              haltOnErr,
  output logic              busy,
  output logic              done,
  output logic              passed,
  output logic [PAT_W-1:0]  failPat,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failMask,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  if (DATA_W < 4 || DATA_W > 64 || (DATA_W & (DATA_W - 1)) != 0) begin : g_badWidth
    $error("pattern_bist: DATA_W must be a power of two from 4 to 64");
  end

  bist_strobe_t strobe;
  logic addrLast, patLast, mismatch;

  pattern_bist_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .haltOnErr(haltOnErr),
    .addrLast (addrLast),
    .patLast  (patLast),
    .mismatch (mismatch),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  pattern_bist_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LOG_W  (LOG_W),
    .NUM_PAT(NUM_PAT),
    .PAT_W  (PAT_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .addrLast(addrLast),
    .patLast (patLast),
    .mismatch(mismatch),
    .memEn   (memEn),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memRdata(memRdata),
    .passed  (passed),
    .failPat (failPat),
    .failAddr(failAddr),
    .failMask(failMask)
  );

endmodule

// File: tb/pattern_bist_bench.sv
module pattern_bist_bench;
  localparam int PERIOD  = 10;
  localparam int DW      = 8;
  localparam int AW      = 3;
  localparam int DEPTH   = 1 << AW;
  localparam int LW      = $clog2(DW);
  localparam int NPAT    = 2 * (1 + LW);
  localparam int PW      = $clog2(NPAT);
  localparam int PERIODP = 2 * DEPTH + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, haltOnErr = 1'b0;
  logic busy, done, passed, memEn, memWe;
  logic [PW-1:0] failPat;
  logic [AW-1:0] failAddr, memAddr;
  logic [DW-1:0] failMask, memWdata, memRdata;

  int checks = 0, failures = 0;

  // fault configuration of the memory model
  logic          stEn = 1'b0, brEn = 1'b0;
  logic [AW-1:0] stAddr = '0, brAddr = '0;
  logic [DW-1:0] stMask = '0, stVal = '0;
  int            brBit = 0;
  logic [DW-1:0] mem [DEPTH];

  always #(PERIOD / 2) clk = ~clk;

  pattern_bist #(.DATA_W(DW), .ADDR_W(AW)) u_pattern_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .haltOnErr(haltOnErr),
    .busy(busy), .done(done), .passed(passed), .failPat(failPat),
    .failAddr(failAddr), .failMask(failMask), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [DW-1:0] faulty(input logic [AW-1:0] a, input logic [DW-1:0] w);
    logic [DW-1:0] v;
    v = w;
    if (stEn && a == stAddr) v = (v & ~stMask) | (stVal & stMask);
    if (brEn && a == brAddr) v[brBit] = w[brBit] | w[brBit+1];
    return v;
  endfunction

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata <= faulty(memAddr, mem[memAddr]);
    end
  end

  function automatic logic [DW-1:0] bpat(input int p);
    logic [DW-1:0] v;
    int k;
    k = (p <= LW) ? p : p - (LW + 1);
    for (int i = 0; i < DW; i++)
      v[i] = (k < LW) ? (((i / (DW >> (k + 1))) % 2) == 0) : 1'b0;
    return (p <= LW) ? v : ~v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runTest(input bit halt, input bit poke);
    bit expFail;
    int eP, eA, eIdx, nDone, limit, step, wrErr, ordErr;
    logic [DW-1:0] eMask;
    expFail = 1'b0; eP = 0; eA = 0; eMask = '0;
    for (int p = 0; p < NPAT && !expFail; p++)
      for (int a = 0; a < DEPTH && !expFail; a++) begin
        logic [DW-1:0] r;
        r = faulty(AW'(a), bpat(p));
        if (r != bpat(p)) begin
          expFail = 1'b1; eP = p; eA = a; eMask = r ^ bpat(p);
        end
      end
    eIdx  = eP * PERIODP + DEPTH + eA;
    nDone = (halt && expFail) ? eIdx + 2 : NPAT * PERIODP;
    limit = (halt && expFail) ? eIdx + 1 : nDone;

    @(negedge clk); start = 1'b1; haltOnErr = halt;
    @(posedge clk);
    step = 0; wrErr = 0; ordErr = 0;
    forever begin
      @(negedge clk);
      start = poke && (step == 5 || step == DEPTH + 2);
      haltOnErr = ~halt;
      if (step < limit) begin
        int r, p;
        p = step / PERIODP; r = step % PERIODP;
        if (r < DEPTH) begin
          if (!(memEn && memWe && memAddr == AW'(r))) ordErr++;
          if (memWdata != bpat(p)) wrErr++;
        end else if (r < 2 * DEPTH) begin
          if (!(memEn && !memWe && memAddr == AW'(r - DEPTH))) ordErr++;
        end else if (memEn) ordErr++;
      end
      if (done || step > nDone + 5) break;
      step++;
    end
    start = 1'b0;
    chk(wrErr == 0, "R1", "background write data errors", 64'(wrErr), 0);
    chk(ordErr == 0, "R2", "access order errors", 64'(ordErr), 0);
    chk(step == nDone, (halt && expFail) ? "R7" : "R6", "done cycle", 64'(step), 64'(nDone));
    chk(passed == !expFail, "R3", "passed", 64'(passed), 64'(!expFail));
    chk(failPat == PW'(eP), "R4", "failPat", 64'(failPat), 64'(expFail ? eP : 0));
    chk(failAddr == AW'(eA), "R4", "failAddr", 64'(failAddr), 64'(expFail ? eA : 0));
    chk(failMask == eMask, expFail ? "R4" : "R9", "failMask", 64'(failMask), 64'(eMask));
    @(negedge clk);
    chk(!done && !busy, "R6", "done one cycle", 64'({done, busy}), 0);
    if (poke) chk(step == nDone, "R8", "start while busy ignored", 64'(step), 64'(nDone));
    if (!halt && expFail) chk(step == NPAT * PERIODP, "R5", "continue mode length", 64'(step), 64'(NPAT * PERIODP));
    if (halt && expFail) chk(step == eIdx + 2, "R5", "halt mode length", 64'(step), 64'(eIdx + 2));
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL R6 watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!done && !busy && !memEn, "R9", "reset outputs idle", 64'({done, busy, memEn}), 0);
    chk(passed && failMask == '0 && failAddr == '0 && failPat == '0, "R9", "reset fail state",
        64'({passed, failMask}), 64'({1'b1, {DW{1'b0}}}));
    rst_n = 1'b1;
    @(negedge clk);

    // directed: clean memory in both modes, start poked mid-run
    runTest(1'b0, 1'b0);
    runTest(1'b1, 1'b1);

    // directed: bit 0 stuck at 1 at last address, halt
    stEn = 1'b1; stAddr = AW'(DEPTH - 1); stMask = 8'h01; stVal = 8'h01;
    runTest(1'b1, 1'b0);
    // directed: top bit stuck at 0 at address 0, continue
    stAddr = '0; stMask = 8'h80; stVal = 8'h00;
    runTest(1'b0, 1'b0);
    stEn = 1'b0;

    // directed: adjacent-bit short
    brEn = 1'b1; brAddr = AW'(3); brBit = 2;
    runTest(1'b0, 1'b0);
    runTest(1'b1, 1'b0);

    // random faults, sometimes two at once
    for (int t = 0; t < 8; t++) begin
      stEn   = 1'b1;
      stAddr = AW'($urandom_range(0, DEPTH - 1));
      stMask = DW'($urandom);
      if (stMask == '0) stMask = 8'h10;
      stVal  = DW'($urandom);
      brEn   = ($urandom_range(0, 1) == 1);
      brAddr = AW'($urandom_range(0, DEPTH - 1));
      brBit  = $urandom_range(0, DW - 2);
      runTest(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    // clean run after faulty runs: results cleared by start
    stEn = 1'b0; brEn = 1'b0;
    runTest(1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule